// File: doc/BRIEF.md
# Chroma-Decimating 4:2:2 Downformatter

This block takes full-rate 9-bit luma and two 9-bit colour-difference streams (one sample of each per clock) and turns them into a 4:2:2 stream. Luma leaves on its own output every clock. The two colour-difference streams share a second output, which carries blue-difference and red-difference samples on alternating clocks. A slot flag marks which half of a two-clock slot is on the outputs.

Each colour-difference stream goes through a rounded three-tap smoothing filter before decimation, which limits aliasing. The red-difference path holds one more register, so both chroma samples shown in a slot are centred on the luma sample shown in the first clock of that slot. The luma path's alignment registers also act as an optional peaking filter. The filter has unity DC gain and about 1.9 dB of boost at a quarter of the sample rate, and a limiter follows it. One enable input switches the peaking on or off. The luma latency is the same in both modes.

A two-state slot controller (SLOT_FIRST, SLOT_SECOND) sets the flag and drives the chroma multiplexer. Reset puts it in SLOT_FIRST. It moves SLOT_FIRST -> SLOT_SECOND and SLOT_SECOND -> SLOT_FIRST on every clock. A register follows the multiplexer, so in SLOT_SECOND the multiplexer selects blue-difference, which becomes visible in the following SLOT_FIRST clock. In SLOT_FIRST it selects the delayed red-difference.

Top module: `dfmt_downformatter`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `y_out` and `c_out` are 0 and `slot_phase` is 0. This holds also when reset is asserted in mid-stream.
- R2: `slot_phase` is 0 in the first clock after reset release and inverts on every later clock. Value 0 marks the first clock of a slot and value 1 marks the second.
- R3: Each chroma stream is smoothed as (x[m-1] + 2*x[m] + x[m+1] + 2) >> 2. Here x[k] is the input sampled at rising edge k after reset release, and samples before release count as 0.
- R4: After edge e, when `slot_phase` is 0, `c_out` holds the smoothed blue-difference centred on sample e-2. When `slot_phase` is 1, it holds the smoothed red-difference centred on sample e-3, which is the centre of the luma shown in the slot's first clock.
- R5: With peaking disabled, `y_out` after edge e equals the luma input sampled at edge e-2, unchanged.
- R6: With peaking enabled, `y_out` after edge e equals c + ((2c - p - n + 4) >>> 3), with an arithmetic (floor) shift. Here c = x[e-2], p = x[e-3] and n = x[e-1].
- R7: The peaked luma is limited to 0..511. Sums below 0 give 0 and sums above 511 give 511.
- R8: A luma input held constant for three consecutive samples produces that same value at the output in either mode (unity DC gain).
- R9: `peak_en` sampled at edge e selects the mode for the `y_out` value loaded at that edge only. It changes neither the luma latency nor `c_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| peak_en | input | 1 | 1 enables luma peaking, 0 selects plain delay |
| y_in | input | 9 | Full-rate luma |
| cb_in | input | 9 | Full-rate blue-difference |
| cr_in | input | 9 | Full-rate red-difference |
| y_out | output | 9 | Luma, one per clock |
| c_out | output | 9 | Interleaved chroma: blue-difference when slot_phase is 0, red-difference when 1 |
| slot_phase | output | 1 | Slot flag, 0 in the first clock of a slot |

## Verification
Luma needs two edges to go from input to output: the input sample x[e-2] shows up after edge e, at the same time as its blue-difference partner. The red-difference partner appears one edge later. The bench counts edges from reset release and keeps its own history of every driven sample and enable value. At the falling edge after each rising edge it computes the luma, chroma and flag values that are due for that edge and compares them. Because of this, a result that arrives one clock early or late, or on the wrong slot half, shows up as a miscompare.

// File: rtl/dfmt_pkg.sv
package dfmt_pkg;

    // Two halves of a 4:2:2 output slot.
    typedef enum logic {
        SLOT_FIRST  = 1'b0,   // output shows blue-difference
        SLOT_SECOND = 1'b1    // output shows red-difference
    } slot_state_t;

    localparam int CHAN_CB    = 0;
    localparam int CHAN_CR    = 1;
    localparam int NUM_CHROMA = 2;

endpackage

// File: rtl/dfmt_slot_fsm.sv
module dfmt_slot_fsm
    import dfmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic slot_phase,
    output logic mux_pick_cb
);

    slot_state_t state_q;
    slot_state_t state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: the slot halves alternate on every clock.
    always_comb begin
        state_d = SLOT_FIRST;
        unique case (state_q)
            SLOT_FIRST:  state_d = SLOT_SECOND;
            SLOT_SECOND: state_d = SLOT_FIRST;
            default:     state_d = SLOT_FIRST;
        endcase
    end

    // Outputs. The chroma mux feeds a register, so it prepares the
    // sample of the other slot half.
    always_comb begin
        slot_phase  = 1'b0;
        mux_pick_cb = 1'b0;
        unique case (state_q)
            SLOT_FIRST: begin
                slot_phase  = 1'b0;
                mux_pick_cb = 1'b0;
            end
            SLOT_SECOND: begin
                slot_phase  = 1'b1;
                mux_pick_cb = 1'b1;
            end
            default: begin
                slot_phase  = 1'b0;
                mux_pick_cb = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dfmt_chroma_lpf.sv
module dfmt_chroma_lpf #(
    parameter int DW        = 9,
    parameter int EXTRA_DLY = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    localparam int AW = DW + 2;
    localparam logic [AW-1:0] ROUND = AW'(2);

    logic [DW-1:0] tap1_q;
    logic [DW-1:0] tap2_q;
    logic [DW-1:0] lp_q;
    logic [AW-1:0] acc;

    // Weighted sum 1-2-1 with rounding.
    always_comb begin
        acc = {2'b00, din} + {1'b0, tap1_q, 1'b0} + {2'b00, tap2_q} + ROUND;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap1_q <= '0;
            tap2_q <= '0;
            lp_q   <= '0;
        end else begin
            tap1_q <= din;
            tap2_q <= tap1_q;
            lp_q   <= DW'(acc >> 2);
        end
    end

    generate
        if (EXTRA_DLY != 0) begin : g_align
            logic [DW-1:0] align_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    align_q <= '0;
                end else begin
                    align_q <= lp_q;
                end
            end
            assign dout = align_q;
        end else begin : g_direct
            assign dout = lp_q;
        end
    endgenerate

endmodule

// File: rtl/dfmt_luma_peak.sv
module dfmt_luma_peak #(
    parameter int DW         = 9,
    parameter int PEAK_NUM   = 1,
    parameter int PEAK_SHIFT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          peak_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    localparam int SW = DW + 12;
    localparam logic signed [SW-1:0] K_COEF = SW'(PEAK_NUM);
    localparam logic signed [SW-1:0] K_RND  = SW'(1) <<< (PEAK_SHIFT - 1);
    localparam logic signed [SW-1:0] Y_MAX  = SW'((1 << DW) - 1);

    logic [DW-1:0] d1_q;
    logic [DW-1:0] d2_q;
    logic [DW-1:0] d3_q;
    logic [DW-1:0] y_q;

    logic signed [SW-1:0] nxt_s;
    logic signed [SW-1:0] ctr_s;
    logic signed [SW-1:0] prv_s;
    logic signed [SW-1:0] hp_s;
    logic signed [SW-1:0] prod_s;
    logic signed [SW-1:0] boost_s;
    logic signed [SW-1:0] sum_s;
    logic [DW-1:0]        peaked;

    // High-pass on the centre tap, scaled, added back and limited.
    always_comb begin
        nxt_s   = $signed({{(SW-DW){1'b0}}, d1_q});
        ctr_s   = $signed({{(SW-DW){1'b0}}, d2_q});
        prv_s   = $signed({{(SW-DW){1'b0}}, d3_q});
        hp_s    = (ctr_s <<< 1) - nxt_s - prv_s;
        prod_s  = hp_s * K_COEF;
        boost_s = (prod_s + K_RND) >>> PEAK_SHIFT;
        sum_s   = ctr_s + boost_s;
        if (sum_s < 0) begin
            peaked = '0;
        end else if (sum_s > Y_MAX) begin
            peaked = '1;
        end else begin
            peaked = sum_s[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d1_q <= '0;
            d2_q <= '0;
            d3_q <= '0;
            y_q  <= '0;
        end else begin
            d1_q <= din;
            d2_q <= d1_q;
            d3_q <= d2_q;
            y_q  <= peak_en ? peaked : d2_q;
        end
    end

    assign dout = y_q;

endmodule

// File: rtl/dfmt_downformatter.sv
module dfmt_downformatter
    import dfmt_pkg::*;
#(
    parameter int DW         = 9,
    parameter int PEAK_NUM   = 1,
    parameter int PEAK_SHIFT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          peak_en,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] cb_in,
    input  logic [DW-1:0] cr_in,
    output logic [DW-1:0] y_out,
    output logic [DW-1:0] c_out,
    output logic          slot_phase
);

    logic [DW-1:0] c_src  [NUM_CHROMA];
    logic [DW-1:0] c_filt [NUM_CHROMA];
    logic          mux_pick_cb;
    logic [DW-1:0] c_q;

    assign c_src[CHAN_CB] = cb_in;
    assign c_src[CHAN_CR] = cr_in;

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CHROMA; ch++) begin : g_chroma
            dfmt_chroma_lpf #(
                .DW        (DW),
                .EXTRA_DLY ((ch == CHAN_CR) ? 1 : 0)
            ) lpf_i (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (c_src[ch]),
                .dout  (c_filt[ch])
            );
        end
    endgenerate

    dfmt_slot_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_phase  (slot_phase),
        .mux_pick_cb (mux_pick_cb)
    );

    // Chroma multiplexer and its output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= mux_pick_cb ? c_filt[CHAN_CB] : c_filt[CHAN_CR];
        end
    end

    assign c_out = c_q;

    dfmt_luma_peak #(
        .DW         (DW),
        .PEAK_NUM   (PEAK_NUM),
        .PEAK_SHIFT (PEAK_SHIFT)
    ) luma_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .peak_en (peak_en),
        .din     (y_in),
        .dout    (y_out)
    );

endmodule

// File: rtl/dfmt_downformatter_chk.sv
module dfmt_downformatter_chk #(
    parameter int DW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          peak_en,
    input logic [DW-1:0] y_in,
    input logic [DW-1:0] cb_in,
    input logic [DW-1:0] cr_in,
    input logic [DW-1:0] y_out,
    input logic [DW-1:0] c_out,
    input logic          slot_phase
);

    // Edges seen since reset release, saturating.
    logic [2:0] live_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_cnt <= '0;
        end else if (live_cnt != 3'd7) begin
            live_cnt <= live_cnt + 3'd1;
        end
    end

    function automatic logic [DW-1:0] smooth3(input logic [DW-1:0] a,
                                              input logic [DW-1:0] b,
                                              input logic [DW-1:0] c);
        logic [DW+1:0] s;
        s = {2'b00, a} + {1'b0, b, 1'b0} + {2'b00, c} + (DW+2)'(2);
        return DW'(s >> 2);
    endfunction

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (y_out == '0 && c_out == '0 && !slot_phase));

    assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 3'd1) |-> (slot_phase != $past(slot_phase)));

    assert_cb_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 3'd4 && !slot_phase) |->
        (c_out == smooth3($past(cb_in, 4), $past(cb_in, 3), $past(cb_in, 2))));

    assert_cr_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 3'd5 && slot_phase) |->
        (c_out == smooth3($past(cr_in, 5), $past(cr_in, 4), $past(cr_in, 3))));

    assert_bypass_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 3'd3 && !$past(peak_en)) |-> (y_out == $past(y_in, 3)));

    assert_dc_unity_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 3'd5 && $past(y_in, 2) == $past(y_in, 3)
                          && $past(y_in, 4) == $past(y_in, 3)) |->
        (y_out == $past(y_in, 3)));

endmodule

bind dfmt_downformatter dfmt_downformatter_chk #(.DW(DW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .peak_en    (peak_en),
    .y_in       (y_in),
    .cb_in      (cb_in),
    .cr_in      (cr_in),
    .y_out      (y_out),
    .c_out      (c_out),
    .slot_phase (slot_phase)
);

// File: tb/dfmt_downformatter_tb_top.sv
module dfmt_downformatter_tb_top;

    localparam int DW   = 9;
    localparam int HMAX = 4096;

    logic          clk     = 1'b0;
    logic          rst_n   = 1'b0;
    logic          peak_en = 1'b0;
    logic [DW-1:0] y_in    = '0;
    logic [DW-1:0] cb_in   = '0;
    logic [DW-1:0] cr_in   = '0;
    logic [DW-1:0] y_out;
    logic [DW-1:0] c_out;
    logic          slot_phase;

    int n_vec  = 0;
    int n_fail = 0;
    int e_idx  = 0;
    bit done   = 1'b0;

    int hy  [HMAX];
    int hcb [HMAX];
    int hcr [HMAX];
    bit hen [HMAX];

    always #5 clk = ~clk;

    dfmt_downformatter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .peak_en    (peak_en),
        .y_in       (y_in),
        .cb_in      (cb_in),
        .cr_in      (cr_in),
        .y_out      (y_out),
        .c_out      (c_out),
        .slot_phase (slot_phase)
    );

    // ---------------- reference model (from the requirements) -------------
    function automatic int hist(input int sel, input int k);
        if (k < 0) return 0;
        case (sel)
            0: return hy[k];
            1: return hcb[k];
            default: return hcr[k];
        endcase
    endfunction

    function automatic int smooth(input int sel, input int m);
        return (hist(sel, m-1) + 2*hist(sel, m) + hist(sel, m+1) + 2) >> 2;
    endfunction

    function automatic int luma_exp(input int e);
        int c, p, n, s;
        c = hist(0, e-2);
        p = hist(0, e-3);
        n = hist(0, e-1);
        if (!hen[e]) return c;
        s = c + ((2*c - p - n + 4) >>> 3);
        if (s < 0)   s = 0;
        if (s > 511) s = 511;
        return s;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", tag, what, act, exp, e_idx);
        end
    endtask

    // Drive one sample set at a falling edge, let the rising edge pass,
    // then check the outputs due for that edge.
    task automatic tick(input int yv, input int cbv, input int crv, input bit en,
                        input string ytag, input string ctag);
        int ph;
        y_in    = DW'(yv);
        cb_in   = DW'(cbv);
        cr_in   = DW'(crv);
        peak_en = en;
        hy[e_idx]  = yv;
        hcb[e_idx] = cbv;
        hcr[e_idx] = crv;
        hen[e_idx] = en;
        @(posedge clk);
        @(negedge clk);
        ph = (e_idx + 1) & 1;
        check("R2", "slot_phase", int'(slot_phase), ph);
        if (ph == 0) check(ctag, "c_out(cb)", int'(c_out), smooth(1, e_idx - 2));
        else         check(ctag, "c_out(cr)", int'(c_out), smooth(2, e_idx - 3));
        check(ytag, "y_out", int'(y_out), luma_exp(e_idx));
        e_idx++;
    endtask

    task automatic flush(input int n, input bit en);
        for (int i = 0; i < n; i++) tick(0, 0, 0, en, en ? "R6" : "R5", "R4");
    endtask

    // R1: reset state, then release aligned to a falling edge.
    task automatic t_reset(input bit midrun);
        @(negedge clk);
        rst_n = 1'b0;
        y_in = '0; cb_in = '0; cr_in = '0; peak_en = 1'b0;
        #1;
        check("R1", midrun ? "y_out async" : "y_out", int'(y_out), 0);
        check("R1", "c_out", int'(c_out), 0);
        check("R1", "slot_phase", int'(slot_phase), 0);
        repeat (3) @(negedge clk);
        check("R1", "y_out held", int'(y_out), 0);
        check("R1", "c_out held", int'(c_out), 0);
        rst_n = 1'b1;
        e_idx = 0;
    endtask

    // R5: bypass luma ramp, R3/R4 chroma ramps.
    task automatic t_bypass_ramp();
        for (int i = 0; i < 40; i++) tick(i * 12, 500 - i * 7, i * 9, 1'b0, "R5", "R3");
        flush(4, 1'b0);
    endtask

    // R4: isolated impulses on each chroma input show slot alignment.
    task automatic t_chroma_impulse();
        for (int i = 0; i < 24; i++)
            tick(i, (i == 6) ? 400 : 0, (i == 11 || i == 12) ? 300 : 0, 1'b0, "R5", "R4");
        flush(4, 1'b0);
    endtask

    // R6: quarter-rate luma pattern with peaking on.
    task automatic t_peak_fs4();
        int pat [4] = '{356, 256, 156, 256};
        for (int i = 0; i < 32; i++) tick(pat[i % 4], 128, 384, 1'b1, "R6", "R4");
        flush(3, 1'b1);
    endtask

    // R7: full-scale steps drive the peaking past both limits.
    task automatic t_clip_steps();
        for (int i = 0; i < 24; i++) tick(((i / 4) % 2) ? 511 : 0, 256, 256, 1'b1, "R7", "R4");
        flush(3, 1'b1);
    endtask

    // R8: constant luma is passed unchanged in both modes.
    task automatic t_dc_const();
        for (int i = 0; i < 10; i++) tick(333, 200, 100, 1'b1, "R8", "R4");
        for (int i = 0; i < 10; i++) tick(77, 200, 100, 1'b0, "R8", "R4");
        for (int i = 0; i < 10; i++) tick(511, 511, 0, 1'b1, "R8", "R4");
    endtask

    // R9: enable toggled every few clocks; chroma and latency unaffected.
    task automatic t_peak_toggle();
        for (int i = 0; i < 40; i++)
            tick((i % 3 == 0) ? 450 : 60, i * 11, 511 - i * 5, ((i / 3) % 2) == 1, "R9", "R9");
        flush(3, 1'b0);
    endtask

    // Mixed random stimulus covering all requirements together.
    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            bit en;
            en = (i / 25) % 2 == 1;
            tick(int'($urandom_range(0, 511)), int'($urandom_range(0, 511)),
                 int'($urandom_range(0, 511)), en, en ? "R6" : "R5", "R4");
        end
    endtask

    initial begin
        t_reset(1'b0);
        t_bypass_ramp();
        t_chroma_impulse();
        t_peak_fs4();
        t_clip_steps();
        t_dc_const();
        t_peak_toggle();
        for (int i = 0; i < 7; i++) tick(300 + i, 400, 50, 1'b1, "R6", "R4");
        t_reset(1'b1);          // R1 mid-stream reset
        t_random();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        #(1_000_000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule